// File: doc/BRIEF.md
# Programmable Color Matrix Converter

This block converts a stream of 8-bit three-channel pixels through a programmable 3x3 matrix with a per-row additive offset. Loaded with the right constants it converts RGB to YCbCr, YCbCr to RGB, or rescales full-range RGB to limited range. Every output channel is a weighted sum of the three input channels plus that row's offset. The result is rounded to the nearest integer and saturated to the 8-bit range.

The constants sit in a 24-byte staging bank written one byte at a time through a small write port. The staged set is copied into the working set only at the start of a data-enable run. A line of pixels therefore never mixes two sets, even when software rewrites the bank mid-line. Each pixel carries its own matrix-enable and channel-swap bits. Its valid and data-enable flags come out with the same fixed three-cycle latency as the pixel data, whether the matrix is used or bypassed.

Top module: `pix_color_matrix`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_de` and all three output channels are 0, and both the staged and the working coefficient sets are cleared to zero.
- R2: `out_valid` and `out_de` equal `in_valid` and `in_de` as sampled exactly three rising clock edges earlier. The output channels have the same three-edge latency in every mode.
- R3: A write with `cfg_we` high at byte address `a` (0 to 23) stores `cfg_wdata` into field `a/2`. The even address holds the high byte and the odd address the low byte. Field `n` belongs to row `n/4`, slot `n%4`. Slots 0, 1 and 2 weight input channels 0, 1 and 2. Slot 3 is the row's offset. Writes to addresses 24 to 31 change nothing.
- R4: A weight field holds its magnitude in bits 11:0 in units of 1/1024, and bit 12 set makes it negative. Bits 15:13 are ignored.
- R5: An offset field holds an integer magnitude in bits 8:0, and bit 9 set makes it negative. Bits 15:10 are ignored.
- R6: With the matrix enabled, output channel `r` is floor((w[r][0]*c0 + w[r][1]*c1 + w[r][2]*c2 + 1024*off[r] + 512) / 1024), where the weights are in 1/1024 units. This rounds half up.
- R7: A result of R6 below 0 gives 0, and a result above 255 gives 255.
- R8: When a pixel's `csc_en` is low, its output channels equal its input channels.
- R9: When a pixel's `swap_en` is high, output channels 0 and 2 are exchanged after the matrix or the bypass. Channel 1 is unaffected.
- R10: The staged set becomes the working set in a cycle where `in_de` is 1 and was 0 in the previous cycle. The pixel of that cycle and all later pixels use the new set. Bytes written at any other time do not affect pixels until the next such cycle.
- R11: `csc_en` and `swap_en` are sampled together with each pixel, so they may change from one pixel to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient byte write strobe |
| cfg_addr | input | 5 | Coefficient byte address |
| cfg_wdata | input | 8 | Coefficient byte value |
| csc_en | input | 1 | Per-pixel matrix enable (0 = bypass) |
| swap_en | input | 1 | Per-pixel exchange of output channels 0 and 2 |
| in_valid | input | 1 | Input pixel valid |
| in_de | input | 1 | Input data enable |
| in_c0 | input | 8 | Input channel 0 |
| in_c1 | input | 8 | Input channel 1 |
| in_c2 | input | 8 | Input channel 2 |
| out_valid | output | 1 | Delayed valid |
| out_de | output | 1 | Delayed data enable |
| out_c0 | output | 8 | Output channel 0 |
| out_c1 | output | 8 | Output channel 1 |
| out_c2 | output | 8 | Output channel 2 |

## Verification
Properties check several behaviours on every cycle:
- the three-edge alignment of valid and data-enable;
- exact pass-through of bypassed pixels, with and without the swap;
- saturation of negative and oversized sums to the rail values;
- the working coefficient set holding still except at a data-enable rising edge;
- out-of-range byte writes leaving the staging bank untouched.

The arithmetic itself, the bit layout of weights and offsets, the byte ordering of the bank and the deferral of a mid-line write to the next line can only be shown by the bench's scenarios. Those scenarios compare every output cycle against an arithmetic model of the matrix over dense sweeps of YCbCr and RGB inputs.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int NUM_CH         = 3;
    localparam int FIELDS_PER_ROW = NUM_CH + 1;
    localparam int FIELD_W        = 16;
    localparam int BYTE_W         = 8;

    typedef struct packed {
        logic valid;
        logic de;
        logic mat_en;
        logic swap;
    } ctl_t;

endpackage

// File: rtl/pcm_coef_bank.sv
module pcm_coef_bank
    import pcm_pkg::*;
#(
    parameter  int NUM_BYTES = NUM_CH * FIELDS_PER_ROW * (FIELD_W / BYTE_W),
    localparam int ADDR_W    = $clog2(NUM_BYTES),
    localparam int BPF       = FIELD_W / BYTE_W
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic                                               wr_en_i,
    input  logic [ADDR_W-1:0]                                  wr_addr_i,
    input  logic [BYTE_W-1:0]                                  wr_data_i,
    input  logic                                               de_i,
    output logic [NUM_CH-1:0][FIELDS_PER_ROW-1:0][FIELD_W-1:0] field_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0]                   stg;
        logic [NUM_CH-1:0][FIELDS_PER_ROW-1:0][FIELD_W-1:0] act;
        logic                                               prev_de;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NUM_CH-1:0][FIELDS_PER_ROW-1:0][FIELD_W-1:0] stg_view;
    logic de_rise;

    // Staged bytes regrouped into fields, high byte at the lower address.
    always_comb begin
        for (int r = 0; r < NUM_CH; r++) begin
            for (int f = 0; f < FIELDS_PER_ROW; f++) begin
                for (int b = 0; b < BPF; b++) begin
                    stg_view[r][f][FIELD_W-1-b*BYTE_W -: BYTE_W] =
                        st_q.stg[(r*FIELDS_PER_ROW + f)*BPF + b];
                end
            end
        end
    end

    assign de_rise = de_i & ~st_q.prev_de;

    always_comb begin
        st_d         = st_q;
        st_d.prev_de = de_i;
        if (de_rise) begin
            st_d.act = stg_view;
        end
        if (wr_en_i && (wr_addr_i <= LAST_ADDR)) begin
            st_d.stg[wr_addr_i] = wr_data_i;
        end
        // The first pixel of a run already sees the freshly staged set.
        field_o = de_rise ? stg_view : st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: the working set changes only at a data-enable rising edge
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !de_rise |=> $stable(st_q.act));

    // R3: writes beyond the bank leave the staged bytes untouched
    assert_addr_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || (wr_addr_i > LAST_ADDR)) |=> $stable(st_q.stg));

endmodule

// File: rtl/pcm_row.sv
module pcm_row
    import pcm_pkg::*;
#(
    parameter  int PIX_W  = 8,
    parameter  int FRAC_W = 10,
    parameter  int CMAG_W = 12,
    parameter  int OMAG_W = 9,
    localparam int CW     = CMAG_W + 1,
    localparam int OW     = OMAG_W + 1,
    localparam int PW     = PIX_W + 1 + CW,
    localparam int SW     = PW + 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_CH-1:0][PIX_W-1:0]           pix_i,
    input  logic [FIELDS_PER_ROW-1:0][FIELD_W-1:0] field_i,
    output logic [PIX_W-1:0]                       res_o
);

    localparam int HALF = 1 << (FRAC_W - 1);
    localparam int MAXV = (1 << PIX_W) - 1;

    typedef struct packed {
        logic [NUM_CH-1:0][PW-1:0] prod;
        logic [OW-1:0]             off;
        logic [SW-1:0]             sum;
        logic [PIX_W-1:0]          res;
    } row_st_t;

    row_st_t st_d, st_q;

    logic        [CMAG_W-1:0] mag   [NUM_CH];
    logic signed [CW-1:0]     coef  [NUM_CH];
    logic        [OMAG_W-1:0] omag;
    logic signed [OW-1:0]     offv;
    logic signed [SW-1:0]     total;
    logic signed [SW-1:0]     scaled;

    always_comb begin
        st_d = st_q;

        // Stage 1: sign-magnitude decode and the three products
        for (int k = 0; k < NUM_CH; k++) begin
            mag[k]  = field_i[k][CMAG_W-1:0];
            coef[k] = field_i[k][CMAG_W] ? -$signed({1'b0, mag[k]})
                                         :  $signed({1'b0, mag[k]});
            st_d.prod[k] = PW'($signed({1'b0, pix_i[k]})) * PW'(coef[k]);
        end
        omag     = field_i[FIELDS_PER_ROW-1][OMAG_W-1:0];
        offv     = field_i[FIELDS_PER_ROW-1][OMAG_W] ? -$signed({1'b0, omag})
                                                     :  $signed({1'b0, omag});
        st_d.off = offv;

        // Stage 2: sum with the scaled offset and the rounding half
        total = SW'($signed(st_q.prod[0])) + SW'($signed(st_q.prod[1]))
              + SW'($signed(st_q.prod[2]))
              + (SW'($signed(st_q.off)) <<< FRAC_W) + SW'(HALF);
        st_d.sum = total;

        // Stage 3: drop the fraction and saturate
        scaled = $signed(st_q.sum) >>> FRAC_W;
        if (scaled < 0) begin
            st_d.res = '0;
        end else if (scaled > SW'(MAXV)) begin
            st_d.res = '1;
        end else begin
            st_d.res = scaled[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;

    // R7: a negative rounded sum saturates to zero
    assert_clamp_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(st_q.sum) < 0) |=> (res_o == '0));

    // R7: an oversized rounded sum saturates to full scale
    assert_clamp_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($signed(st_q.sum) >>> FRAC_W) > SW'(MAXV)) |=> (res_o == '1));

endmodule

// File: rtl/pix_color_matrix.sv
module pix_color_matrix
    import pcm_pkg::*;
#(
    parameter  int PIX_W     = 8,
    parameter  int FRAC_W    = 10,
    parameter  int CMAG_W    = 12,
    parameter  int OMAG_W    = 9,
    localparam int NUM_BYTES = NUM_CH * FIELDS_PER_ROW * (FIELD_W / BYTE_W),
    localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              csc_en,
    input  logic              swap_en,
    input  logic              in_valid,
    input  logic              in_de,
    input  logic [PIX_W-1:0]  in_c0,
    input  logic [PIX_W-1:0]  in_c1,
    input  logic [PIX_W-1:0]  in_c2,
    output logic              out_valid,
    output logic              out_de,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2
);

    // Pipeline depth of the row datapath: multiply, add, round/clamp.
    localparam int LAT = 3;

    typedef struct packed {
        ctl_t                          ctl;
        logic [NUM_CH-1:0][PIX_W-1:0]  pix;
    } stage_t;

    typedef struct packed {
        stage_t [LAT-1:0] pipe;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_CH-1:0][FIELDS_PER_ROW-1:0][FIELD_W-1:0] act_fields;
    logic [NUM_CH-1:0][PIX_W-1:0] in_pix;
    logic [NUM_CH-1:0][PIX_W-1:0] mat_res;
    logic [NUM_CH-1:0][PIX_W-1:0] sel_pix;
    stage_t                       last;

    assign in_pix = {in_c2, in_c1, in_c0};

    pcm_coef_bank #(
        .NUM_BYTES (NUM_BYTES)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_we),
        .wr_addr_i (cfg_addr),
        .wr_data_i (cfg_wdata),
        .de_i      (in_de),
        .field_o   (act_fields)
    );

    for (genvar r = 0; r < NUM_CH; r++) begin : g_row
        pcm_row #(
            .PIX_W  (PIX_W),
            .FRAC_W (FRAC_W),
            .CMAG_W (CMAG_W),
            .OMAG_W (OMAG_W)
        ) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .pix_i   (in_pix),
            .field_i (act_fields[r]),
            .res_o   (mat_res[r])
        );
    end

    always_comb begin
        st_d                    = st_q;
        st_d.pipe[0].ctl.valid  = in_valid;
        st_d.pipe[0].ctl.de     = in_de;
        st_d.pipe[0].ctl.mat_en = csc_en;
        st_d.pipe[0].ctl.swap   = swap_en;
        st_d.pipe[0].pix        = in_pix;
        for (int i = 1; i < LAT; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        last      = st_q.pipe[LAT-1];
        sel_pix   = last.ctl.mat_en ? mat_res : last.pix;
        out_valid = last.ctl.valid;
        out_de    = last.ctl.de;
        out_c0    = last.ctl.swap ? sel_pix[2] : sel_pix[0];
        out_c1    = sel_pix[1];
        out_c2    = last.ctl.swap ? sel_pix[0] : sel_pix[2];
    end

    // Cycles since reset, so that the depth-3 history below is always defined.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R2: flags leave exactly three edges after they enter
    assert_flag_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> ((out_valid == $past(in_valid, 3)) &&
                              (out_de == $past(in_de, 3))));

    // R8: a bypassed, unswapped pixel is passed through unchanged
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd3) && !$past(csc_en, 3) && !$past(swap_en, 3)) |->
        ((out_c0 == $past(in_c0, 3)) && (out_c1 == $past(in_c1, 3)) &&
         (out_c2 == $past(in_c2, 3))));

    // R9: a bypassed, swapped pixel has its outer channels exchanged
    assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd3) && !$past(csc_en, 3) && $past(swap_en, 3)) |->
        ((out_c0 == $past(in_c2, 3)) && (out_c1 == $past(in_c1, 3)) &&
         (out_c2 == $past(in_c0, 3))));

endmodule

// File: tb/test_pix_color_matrix.sv
module test_pix_color_matrix;

    localparam int NB = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       csc_en = 1'b0;
    logic       swap_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_de = 1'b0;
    logic [7:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic       out_valid, out_de;
    logic [7:0] out_c0, out_c1, out_c2;

    always #4 clk = ~clk;

    pix_color_matrix i_pix_color_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .csc_en(csc_en), .swap_en(swap_en),
        .in_valid(in_valid), .in_de(in_de), .in_c0(in_c0), .in_c1(in_c1),
        .in_c2(in_c2), .out_valid(out_valid), .out_de(out_de),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    chk_on = 1'b0;

    // Bench model of the bank, per R3/R4/R5/R10.
    logic [7:0]  stg_m [NB];
    logic [7:0]  act_m [NB];
    bit          prev_de_m;
    logic [15:0] set_f [12];

    typedef struct packed {
        logic       v;
        logic       de;
        logic [7:0] c0;
        logic [7:0] c1;
        logic [7:0] c2;
    } exp_t;
    exp_t pipe_m [3];

    function automatic int fld(bit from_stg, int r, int f);
        int i = (r*4 + f)*2;
        logic [15:0] w;
        w = from_stg ? {stg_m[i], stg_m[i+1]} : {act_m[i], act_m[i+1]};
        return int'(w);
    endfunction

    function automatic int wgt(int w);
        int m = w & 'hFFF;
        return ((w & 'h1000) != 0) ? -m : m;
    endfunction

    function automatic int ofs(int w);
        int m = w & 'h1FF;
        return ((w & 'h200) != 0) ? -m : m;
    endfunction

    function automatic logic [7:0] row_out(bit s, int r, int x0, int x1, int x2);
        int acc;
        int q;
        acc = wgt(fld(s, r, 0))*x0 + wgt(fld(s, r, 1))*x1 + wgt(fld(s, r, 2))*x2
            + ofs(fld(s, r, 3))*1024 + 512;
        q = acc >>> 10;
        if (q < 0) return 8'd0;
        if (q > 255) return 8'd255;
        return 8'(q);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) pipe_m[i] = '0;
            for (int i = 0; i < NB; i++) begin
                stg_m[i] = '0;
                act_m[i] = '0;
            end
            prev_de_m = 1'b0;
        end else begin
            exp_t e;
            bit   use_new;
            logic [7:0] o0, o1, o2, t;
            use_new = in_de && !prev_de_m;
            if (csc_en) begin
                o0 = row_out(use_new, 0, in_c0, in_c1, in_c2);
                o1 = row_out(use_new, 1, in_c0, in_c1, in_c2);
                o2 = row_out(use_new, 2, in_c0, in_c1, in_c2);
            end else begin
                o0 = in_c0;
                o1 = in_c1;
                o2 = in_c2;
            end
            if (swap_en) begin
                t  = o0;
                o0 = o2;
                o2 = t;
            end
            e = '{v: in_valid, de: in_de, c0: o0, c1: o1, c2: o2};
            pipe_m[2] = pipe_m[1];
            pipe_m[1] = pipe_m[0];
            pipe_m[0] = e;
            if (use_new) begin
                for (int i = 0; i < NB; i++) act_m[i] = stg_m[i];
            end
            prev_de_m = in_de;
            if (cfg_we && (cfg_addr < 5'd24)) stg_m[cfg_addr] = cfg_wdata;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on) begin
            exp_t g;
            g = '{v: out_valid, de: out_de, c0: out_c0, c1: out_c1, c2: out_c2};
            n_chk++;
            if (g !== pipe_m[2]) begin
                n_err++;
                $display("FAIL %s: stream got %h expected %h", cur_req, g, pipe_m[2]);
            end
        end
    end

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(bit v, bit de, bit en, bit sw, int a, int b, int c);
        @(negedge clk);
        in_valid = v;
        in_de    = de;
        csc_en   = en;
        swap_en  = sw;
        in_c0    = 8'(a);
        in_c1    = 8'(b);
        in_c2    = 8'(c);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr_byte(int a, int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 5'(a);
        cfg_wdata = 8'(d);
    endtask

    task automatic wr_end();
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_set();
        for (int n = 0; n < 12; n++) begin
            wr_byte(2*n, set_f[n][15:8]);
            wr_byte(2*n + 1, set_f[n][7:0]);
        end
        wr_end();
    endtask

    // One matrix pixel at a data-enable rising edge; returns when its result is visible.
    task automatic fire(int a, int b, int c);
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(1, 1, 1, 0, a, b, c);
        drive(0, 0, 1, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 out_de in reset", out_de, 0);
        check("R1 channels in reset", {out_c0, out_c1, out_c2}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_on = 1'b1;

        // Flag latency and bypass over a varied stream
        cur_req = "R2 R8";
        for (int i = 0; i < 300; i++)
            drive(i % 5 != 0, i % 7 != 0, 0, 0, i & 255, (255 - i) & 255, (i*37) & 255);

        cur_req = "R9";
        for (int i = 0; i < 200; i++)
            drive(1, 1, 0, i % 2, (i*3) & 255, (i*11) & 255, (200 - i) & 255);
        idle(4);

        // Full-to-limited range set: weight 0x036F on the diagonal, offset +16
        cur_req = "R6";
        set_f = '{16'h036F, 16'h0000, 16'h0000, 16'h0010,
                  16'h0000, 16'h036F, 16'h0000, 16'h0010,
                  16'h0000, 16'h0000, 16'h036F, 16'h0010};
        load_set();
        fire(0, 0, 0);
        check("R6 black c0", out_c0, 16);
        check("R6 black c1", out_c1, 16);
        check("R6 black c2", out_c2, 16);
        fire(255, 255, 255);
        check("R6 white c0", out_c0, 235);
        check("R6 white c2", out_c2, 235);
        fire(255, 0, 128);
        check("R6 mixed c1", out_c1, 16);
        check("R6 mixed c2", out_c2, 126);
        for (int i = 0; i < 512; i++)
            drive(1, (i % 64) < 60, 1, i % 3 == 0, i & 255, (i*5) & 255, (i*29) & 255);
        idle(4);

        // YCbCr to RGB set with negative weights and offsets
        cur_req = "R7";
        set_f = '{16'h04A7, 16'h0000, 16'h0662, 16'h02CC,
                  16'h04A7, 16'h1190, 16'h1340, 16'h009A,
                  16'h04A7, 16'h0812, 16'h0000, 16'h0302};
        load_set();
        fire(0, 0, 0);
        check("R7 clamp low c0", out_c0, 0);
        fire(255, 128, 255);
        check("R7 clamp high c0", out_c0, 255);
        for (int y = 0; y < 256; y += 5)
            for (int u = 0; u < 256; u += 17)
                for (int v = 0; v < 256; v += 17)
                    drive(1, 1, 1, 0, y, u, v);
        idle(4);

        // Ignored upper bits of a weight (0xE4A7) and of an offset (0xFECC)
        cur_req = "R4 R5";
        wr_byte(0, 'hE4);
        wr_byte(6, 'hFE);
        wr_end();
        fire(100, 128, 128);
        check("R4 R5 ignored upper bits c0", out_c0, 117);

        // Mid-line rewrite of row 0 offset to -100 (0x0264) is deferred
        cur_req = "R10";
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(1, 1, 1, 0, 100, 128, 128);
        wr_byte(6, 'h02);
        wr_byte(7, 'h64);
        wr_end();
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R10 old set kept mid-line", out_c0, 117);
        idle(1);
        fire(100, 128, 128);
        check("R10 new set at next line", out_c0, 221);
        check("R5 negative offset from new line", out_c0, 221);

        // Out-of-range addresses leave the bank unchanged
        cur_req = "R3";
        for (int a = 24; a < 32; a++) wr_byte(a, 'hFF);
        wr_end();
        fire(100, 128, 128);
        check("R3 writes above 23 ignored", out_c0, 221);

        // Per-pixel enable and swap changes inside one line
        cur_req = "R11";
        for (int i = 0; i < 256; i++)
            drive(1, 1, i % 2, (i / 2) % 2, i, (i*7) & 255, (i*13) & 255);
        idle(6);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule